// File: doc/BRIEF.md
# Strobe-Clocked Parallel Receive Front End

This block takes a 32-bit parallel word stream that an external source clocks in with a free-running strobe, and packs it into a local queue that a downstream serializer drains later. Two active-low qualifiers travel with each strobe edge. One marks the data as valid and the other is a framing marker. Each queued entry holds the data, the framing marker, a flag for a marker that arrived without data, and two user side-band bits. A simple valid/ready read port stands in for the serializer. An entry leaves the queue only on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_valid` never falls while an entry is still waiting, so the reader may hold `rd_ready` low for as long as it needs.

The source side has no ready handshake and is only throttled. `suspend_n` asks the source to pause well before the queue fills, and `not_ready_n` signals that the queue is completely full. If the source ignores both and writes into a full queue, the word is dropped and a sticky `overflow` flag is set. A link-down indication raises `err` unless flow control is set to be ignored, and the error is held long enough for a slow observer to see it. Two side-band output bits copy, registered, the values that the link side recovers.

Top module: `pdp_rx_front`

## Requirements
- R1: All state changes on the rising edge of `rx_clk`. `rst_n` low clears the queue, `overflow`, `err`, `uio_out` and the error hold immediately, without waiting for a clock. While `rst_n` is low, `not_ready_n` is 0.
- R2: On an edge where `rx_valid_n` is 0 and the queue is not full, one entry is queued with `rx_data`, with `sync` equal to the inverse of `rx_sync_n`, and with `sync_only` set to 0. No entry is queued when both qualifiers are 1.
- R3: On an edge where `rx_valid_n` is 1 and `rx_sync_n` is 0, and the queue is not full, a marker-only entry is queued with `sync`=1, `sync_only`=1 and data 0.
- R4: Every queued entry also carries `uio_in` as sampled on the same edge. Entries leave in arrival order through `rd_*`. `rd_valid` is 1 exactly when the queue holds an entry.
- R5: `suspend_n` is 0 when the free space in the queue (DEPTH minus the number held) is SUSP_TH words or fewer, and 1 otherwise.
- R6: `not_ready_n` is 0 while the queue holds DEPTH entries.
- R7: A write attempt into a full queue is dropped, leaving the contents unchanged, and sets `overflow`. `overflow` stays at 1 until reset.
- R8: `err` becomes 1 after any edge at which `link_up` is 0 and `fc_ignore` is 0. After the condition ends, `err` stays at 1 for ERR_HOLD edges in total, counting from the last edge on which the condition was seen. With `fc_ignore` at 1, `err` stays at 0.
- R9: `uio_out` takes the value of `dec_uio` one edge later.
- R10: `rx_dir_n` has no effect on what is queued or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_clk | input | 1 | Free-running receive strobe |
| rx_data | input | 32 | Incoming data word |
| rx_valid_n | input | 1 | Data qualifier, active low |
| rx_sync_n | input | 1 | Framing marker, active low |
| rx_dir_n | input | 1 | Direction input, ignored |
| uio_in | input | 2 | User side-band bits sent with the stream |
| link_up | input | 1 | Link status, 1 when the link is up |
| fc_ignore | input | 1 | 1 to ignore flow control, which suppresses `err` |
| dec_uio | input | 2 | Side-band bits recovered by the link side |
| rd_ready | input | 1 | Reader accepts the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 32 | Head entry data |
| rd_sync | output | 1 | Head entry framing marker |
| rd_sync_only | output | 1 | Head entry is a marker with no data |
| rd_uio | output | 2 | Head entry side-band bits |
| uio_out | output | 2 | Registered copy of `dec_uio` |
| suspend_n | output | 1 | Pause request, active low |
| not_ready_n | output | 1 | 0 when the queue is full or in reset |
| err | output | 1 | Stretched link error |
| overflow | output | 1 | Sticky flag for a write dropped while full |

## Verification
The bench builds the block with DEPTH=32, SUSP_TH=16 and ERR_HOLD=4. With a 32-entry queue, the bench reaches the 16-free-word point where `suspend_n` switches after sixteen writes, and reaches the full queue, `not_ready_n` and the dropped write a few cycles later. ERR_HOLD=4 makes it possible to count the error stretch edge by edge, so a hold that is one edge short or one edge long shows up.

// File: rtl/pdp_rx_pkg.sv
package pdp_rx_pkg;
  localparam int DATA_W = 32;
  localparam int UIO_W  = 2;

  typedef struct packed {
    logic              sync_only;
    logic              sync;
    logic [UIO_W-1:0]  uio;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/pdp_rx_capture.sv
module pdp_rx_capture
  import pdp_rx_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_n_i,
  input  logic              sync_n_i,
  input  logic [UIO_W-1:0]  uio_i,
  output logic              push_o,
  output rx_entry_t         entry_o
);
  logic has_data, has_mark;

  always_comb begin
    has_data = ~valid_n_i;
    has_mark = ~sync_n_i;
    push_o   = has_data | has_mark;
    entry_o.sync      = has_mark;
    entry_o.sync_only = has_mark & ~has_data;
    entry_o.uio       = uio_i;
    entry_o.data      = has_data ? data_i : '0;
  end
endmodule

// File: rtl/pdp_rx_fifo.sv
module pdp_rx_fifo
  import pdp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  rx_entry_t     entry_i,
  input  logic          pop_i,
  output rx_entry_t     head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o,
  output logic [CW-1:0] count_o
);
  rx_entry_t     store [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign head_o  = store[rptr];
  assign count_o = count;

  always_ff @(posedge clk) begin
    if (do_push) store[wptr] <= entry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pdp_rx_status.sv
module pdp_rx_status
  import pdp_rx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SUSP_TH  = 16,
  parameter int ERR_HOLD = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(ERR_HOLD + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    count_i,
  input  logic             full_i,
  input  logic             drop_i,
  input  logic             link_up_i,
  input  logic             fc_ignore_i,
  input  logic [UIO_W-1:0] dec_uio_i,
  output logic             suspend_n_o,
  output logic             not_ready_n_o,
  output logic             err_o,
  output logic             overflow_o,
  output logic [UIO_W-1:0] uio_out_o
);
  localparam int FILL_LIMIT = (DEPTH > SUSP_TH) ? DEPTH - SUSP_TH : 0;

  logic [HW-1:0] hold;
  logic          fault;

  assign fault         = ~link_up_i & ~fc_ignore_i;
  assign suspend_n_o   = (count_i < CW'(FILL_LIMIT));
  assign not_ready_n_o = rst_n & ~full_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      err_o <= 1'b0;
    end else if (fault) begin
      hold  <= HW'(ERR_HOLD - 1);
      err_o <= 1'b1;
    end else if (hold != '0) begin
      hold  <= hold - 1'b1;
      err_o <= 1'b1;
    end else begin
      err_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow_o <= 1'b0;
      uio_out_o  <= '0;
    end else begin
      if (drop_i) overflow_o <= 1'b1;
      uio_out_o <= dec_uio_i;
    end
  end
endmodule

// File: rtl/pdp_rx_front.sv
module pdp_rx_front
  import pdp_rx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int SUSP_TH  = 16,
  parameter int ERR_HOLD = 4,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic              rst_n,
  input  logic              rx_clk,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid_n,
  input  logic              rx_sync_n,
  input  logic              rx_dir_n,
  input  logic [UIO_W-1:0]  uio_in,
  input  logic              link_up,
  input  logic              fc_ignore,
  input  logic [UIO_W-1:0]  dec_uio,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sync,
  output logic              rd_sync_only,
  output logic [UIO_W-1:0]  rd_uio,
  output logic [UIO_W-1:0]  uio_out,
  output logic              suspend_n,
  output logic              not_ready_n,
  output logic              err,
  output logic              overflow
);
  rx_entry_t     in_entry, head;
  logic          push, empty, full, drop;
  logic [CW-1:0] fill_count;
  logic          unused_dir;

  assign unused_dir = rx_dir_n;

  pdp_rx_capture u_cap (
    .data_i    (rx_data),
    .valid_n_i (rx_valid_n),
    .sync_n_i  (rx_sync_n),
    .uio_i     (uio_in),
    .push_o    (push),
    .entry_o   (in_entry)
  );

  pdp_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (rx_clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .entry_i (in_entry),
    .pop_i   (rd_ready),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .drop_o  (drop),
    .count_o (fill_count)
  );

  pdp_rx_status #(.DEPTH(DEPTH), .SUSP_TH(SUSP_TH), .ERR_HOLD(ERR_HOLD)) u_stat (
    .clk           (rx_clk),
    .rst_n         (rst_n),
    .count_i       (fill_count),
    .full_i        (full),
    .drop_i        (drop),
    .link_up_i     (link_up),
    .fc_ignore_i   (fc_ignore),
    .dec_uio_i     (dec_uio),
    .suspend_n_o   (suspend_n),
    .not_ready_n_o (not_ready_n),
    .err_o         (err),
    .overflow_o    (overflow),
    .uio_out_o     (uio_out)
  );

  assign rd_valid     = ~empty;
  assign rd_data      = head.data;
  assign rd_sync      = head.sync;
  assign rd_sync_only = head.sync_only;
  assign rd_uio       = head.uio;
endmodule

// File: rtl/pdp_rx_checker.sv
module pdp_rx_checker
  import pdp_rx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ERR_HOLD = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(ERR_HOLD + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid_n,
  input logic             rx_sync_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             not_ready_n,
  input logic             err,
  input logic             overflow,
  input logic             link_up,
  input logic             fc_ignore,
  input logic [UIO_W-1:0] dec_uio,
  input logic [UIO_W-1:0] uio_out,
  input logic [CW-1:0]    fill_count
);
  logic          past_ok;
  logic [HW-1:0] hold_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hold_left <= '0;
    else if (past_ok && $rose(err))  hold_left <= HW'(ERR_HOLD - 2);
    else if (hold_left != '0)        hold_left <= hold_left - 1'b1;
  end

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_ready_n && !rd_ready) |=> $stable(fill_count));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && overflow) |=> overflow);

  assert_valid_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  assert_idle_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rx_valid_n && rx_sync_n) |=> (fill_count == $past(fill_count) - 1'b1));

  assert_err_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && !fc_ignore) |=> err);

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_left != '0) |-> err);

  assert_uio_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (uio_out == $past(dec_uio)));

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (!not_ready_n && !rd_valid && !overflow && !err));
endmodule

bind pdp_rx_front pdp_rx_checker #(.DEPTH(DEPTH), .ERR_HOLD(ERR_HOLD)) u_chk (
  .clk         (rx_clk),
  .rst_n       (rst_n),
  .rx_valid_n  (rx_valid_n),
  .rx_sync_n   (rx_sync_n),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .not_ready_n (not_ready_n),
  .err         (err),
  .overflow    (overflow),
  .link_up     (link_up),
  .fc_ignore   (fc_ignore),
  .dec_uio     (dec_uio),
  .uio_out     (uio_out),
  .fill_count  (fill_count)
);

// File: tb/tb_pdp_rx_front.sv
module tb_pdp_rx_front;
  localparam int PERIOD   = 10;
  localparam int DEPTH    = 32;
  localparam int SUSP_TH  = 16;
  localparam int ERR_HOLD = 4;
  localparam int NVEC     = 8;

  // vector: {valid_n, sync_n, dir_n, uio[1:0], data[31:0]} then expected
  // {written, sync_only, sync, uio[1:0], data[31:0]}
  localparam logic [73:0] VEC [NVEC] = '{
    {3'b011, 2'd0, 32'hA5A5_0001, 1'b1, 1'b0, 1'b0, 2'd0, 32'hA5A5_0001},
    {3'b110, 2'd3, 32'h0000_DEAD, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
    {3'b000, 2'd2, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 2'd2, 32'h1234_5678},
    {3'b101, 2'd1, 32'hFFFF_0000, 1'b1, 1'b1, 1'b1, 2'd1, 32'h0},
    {3'b010, 2'd1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0},
    {3'b111, 2'd2, 32'h0000_0077, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0},
    {3'b011, 2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd3, 32'hFFFF_FFFF},
    {3'b100, 2'd0, 32'h0000_0001, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0}
  };

  logic        rst_n = 1'b0, clk = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_valid_n = 1'b1, rx_sync_n = 1'b1, rx_dir_n = 1'b1;
  logic [1:0]  uio_in = '0, dec_uio = '0;
  logic        link_up = 1'b1, fc_ignore = 1'b0, rd_ready = 1'b0;
  logic        rd_valid, rd_sync, rd_sync_only, suspend_n, not_ready_n, err, overflow;
  logic [31:0] rd_data;
  logic [1:0]  rd_uio, uio_out;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  pdp_rx_front #(.DEPTH(DEPTH), .SUSP_TH(SUSP_TH), .ERR_HOLD(ERR_HOLD)) dut (
    .rst_n(rst_n), .rx_clk(clk), .rx_data(rx_data), .rx_valid_n(rx_valid_n),
    .rx_sync_n(rx_sync_n), .rx_dir_n(rx_dir_n), .uio_in(uio_in), .link_up(link_up),
    .fc_ignore(fc_ignore), .dec_uio(dec_uio), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_sync(rd_sync), .rd_sync_only(rd_sync_only), .rd_uio(rd_uio),
    .uio_out(uio_out), .suspend_n(suspend_n), .not_ready_n(not_ready_n), .err(err),
    .overflow(overflow)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid_n = 1'b1; rx_sync_n = 1'b1; rd_ready = 1'b0;
  endtask

  // one strobe edge, inputs driven at the falling edge, results seen at the next
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    rx_data = d; rx_valid_n = 1'b0; step(); idle();
  endtask

  task automatic pop_check(input string req, input logic [31:0] d);
    chk({req, " rd_valid"}, 64'(rd_valid), 64'd1);
    chk({req, " data"}, 64'(rd_data), 64'(d));
    rd_ready = 1'b1; step(); rd_ready = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    #(PERIOD * 2 + 2);
    chk("R1 not_ready_n in reset", 64'(not_ready_n), 64'd0);
    chk("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
    chk("R1 err in reset", 64'(err), 64'd0);
    chk("R1 overflow in reset", 64'(overflow), 64'd0);
    chk("R1 uio_out in reset", 64'(uio_out), 64'd0);
    @(negedge clk); rst_n = 1'b1; step();
    chk("R1 not_ready_n after reset", 64'(not_ready_n), 64'd1);
    chk("R5 suspend_n empty", 64'(suspend_n), 64'd1);

    // table walk: R2 R3 R4 R10
    for (int i = 0; i < NVEC; i++) begin
      {rx_valid_n, rx_sync_n, rx_dir_n, uio_in, rx_data} = VEC[i][73:37];
      step();
    end
    idle();
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) begin
        chk($sformatf("R4 vec%0d rd_valid", i), 64'(rd_valid), 64'd1);
        chk($sformatf("R2 vec%0d data", i), 64'(rd_data), 64'(VEC[i][31:0]));
        chk($sformatf("R3 vec%0d sync_only", i), 64'(rd_sync_only), 64'(VEC[i][35]));
        chk($sformatf("R2 vec%0d sync", i), 64'(rd_sync), 64'(VEC[i][34]));
        chk($sformatf("R4 vec%0d uio", i), 64'(rd_uio), 64'(VEC[i][33:32]));
        rd_ready = 1'b1; step(); rd_ready = 1'b0;
      end
    end
    chk("R10 R2 nothing extra queued", 64'(rd_valid), 64'd0);

    // R5 suspend threshold, R6 full, R7 drop
    for (int k = 1; k <= DEPTH; k++) begin
      push(32'h100 + 32'(k));
      if (k == DEPTH - SUSP_TH - 1) chk("R5 suspend_n at 17 free", 64'(suspend_n), 64'd1);
      if (k == DEPTH - SUSP_TH)     chk("R5 suspend_n at 16 free", 64'(suspend_n), 64'd0);
      if (k == DEPTH - 1)           chk("R6 not_ready_n one free", 64'(not_ready_n), 64'd1);
    end
    chk("R6 not_ready_n full", 64'(not_ready_n), 64'd0);
    chk("R7 overflow before drop", 64'(overflow), 64'd0);
    push(32'h0000_0BAD);
    chk("R7 overflow set", 64'(overflow), 64'd1);
    for (int k = 1; k <= DEPTH; k++) pop_check("R7", 32'h100 + 32'(k));
    chk("R7 dropped word absent", 64'(rd_valid), 64'd0);
    chk("R7 overflow sticky", 64'(overflow), 64'd1);
    chk("R6 not_ready_n drained", 64'(not_ready_n), 64'd1);

    // R8 error stretch
    link_up = 1'b0; step(); link_up = 1'b1;
    for (int e = 0; e < ERR_HOLD; e++) begin
      chk($sformatf("R8 err held edge %0d", e), 64'(err), 64'd1);
      step();
    end
    chk("R8 err released", 64'(err), 64'd0);
    fc_ignore = 1'b1; link_up = 1'b0;
    step(); step();
    chk("R8 err gated by fc_ignore", 64'(err), 64'd0);
    fc_ignore = 1'b0; step(); step(); step(); step(); step();
    chk("R8 err during long outage", 64'(err), 64'd1);
    link_up = 1'b1;
    for (int e = 0; e < ERR_HOLD; e++) step();
    chk("R8 err cleared after outage", 64'(err), 64'd0);

    // R9 side-band outputs
    dec_uio = 2'b10; step();
    chk("R9 uio_out follows", 64'(uio_out), 64'd2);
    dec_uio = 2'b01;
    chk("R9 uio_out holds before edge", 64'(uio_out), 64'd2);
    step();
    chk("R9 uio_out second value", 64'(uio_out), 64'd1);

    // R1 asynchronous reset mid-cycle
    push(32'h55); push(32'h66);
    link_up = 1'b0; step(); link_up = 1'b1;
    #(PERIOD/4); rst_n = 1'b0; #1;
    chk("R1 async rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 async overflow", 64'(overflow), 64'd0);
    chk("R1 async err", 64'(err), 64'd0);
    chk("R1 async uio_out", 64'(uio_out), 64'd0);
    chk("R1 async not_ready_n", 64'(not_ready_n), 64'd0);
    @(negedge clk); rst_n = 1'b1; step();
    chk("R1 err hold cleared", 64'(err), 64'd0);
    push(32'h77);
    pop_check("R1 queue restarts", 32'h77);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule